// File: doc/BRIEF.md
# Two-Channel Fly-By Receive DMA

This block moves bytes from two serial receivers into memory without holding them anywhere on the way. When a channel serves a request it drives the memory address and a write strobe for one cycle and acknowledges the peripheral in that same cycle. The peripheral places its byte on the shared data bus while it sees that acknowledge. Each channel keeps a destination address that advances by one per transfer and a transfer count that falls by one. When the count runs out the channel parks itself and raises a completion pulse.

Each channel has a control word with two bits. The run bit sends the channel back to setup mode when it is cleared; in setup mode nothing moves and its address and count may be loaded. The request-enable bit selects whether the peripheral's request line drives transfers. With hardware requests off, software can start single transfers through a control-word write. The first channel takes its hardware request from one of four inputs, picked by a 2-bit select held in a separate configuration word. The second channel listens only to its own receiver. Both channels share one memory port, and the first channel wins when both ask at once.

Registers are written through a single-cycle write strobe with an address. Any register can be read back combinationally on a separate read address.

Top module: `flyby_dma`

## Requirements
- R1: After reset both acknowledges, the write strobe, both done pulses and the memory address are 0. Every register reads back 0, including the source select.
- R2: While a channel's run bit (control bit 0) is 0, no request of any kind produces an acknowledge or write strobe for it.
- R3: While request-enable (control bit 1) is 0, the channel's hardware request lines are ignored even when it is running.
- R4: A request sampled high at a clock edge while the channel is running, enabled and has a nonzero count produces, after that edge, one cycle with its acknowledge and mem_we at 1. In that cycle mem_addr equals the channel's destination register. The destination then reads one higher and the count one lower.
- R5: The transfer that takes the count from 1 to 0 raises the channel's done output in the same cycle as its acknowledge and clears the run bit. Later requests produce no acknowledge.
- R6: The source select (register offset 6, bits 1:0) picks which of the four ch1_dreq bits drives channel 1. Its reset value 0 picks bit 0, and the other three bits are ignored.
- R7: Channel 2 responds only to ch2_dreq. Neither the source select nor any ch1_dreq bit can produce a channel-2 acknowledge.
- R8: When both channels have a request in the same cycle, channel 1 is served first and channel 2 on a later cycle. At most one acknowledge is high in any cycle.
- R9: Writes to a channel's destination (offsets 1 and 4) or count (offsets 2 and 5) are ignored while its run bit is 1.
- R10: Writing a control word (offset 0 or 3) with bit 2 set is a software trigger. It performs exactly one transfer, two cycles after the write is sampled. It is accepted only if, before the write, the run bit was 1 and request-enable was 0; otherwise it is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write offset: 0/3 control, 1/4 destination, 2/5 count, 6 source select |
| reg_wdata | input | DW (32) | Write data |
| reg_raddr | input | 3 | Read offset, same map |
| reg_rdata | output | DW (32) | Combinational read data; control reads {request-enable, run} |
| ch1_dreq | input | NSRC (4) | Candidate request lines for channel 1 |
| ch2_dreq | input | 1 | Request from the second receiver |
| ch1_dack | output | 1 | Channel 1 acknowledge |
| ch2_dack | output | 1 | Channel 2 acknowledge |
| mem_addr | output | ADDR_W (16) | Memory write address |
| mem_we | output | 1 | Memory write strobe |
| ch1_done | output | 1 | Channel 1 count-exhausted pulse |
| ch2_done | output | 1 | Channel 2 count-exhausted pulse |

## Verification
The two channels' transfers are the functions that can meet in one cycle, because both compete for the single memory port. The bench raises channel 1's selected request for one edge and the second receiver's request for two edges, both starting in the same cycle. Channel 1 must acknowledge at its own destination first. Channel 2 must then acknowledge at its own destination in the following cycle, and the two acknowledges must never be high together.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;
  localparam int NUM_CH    = 2;
  localparam int FLD_CTRL  = 0;
  localparam int FLD_DEST  = 1;
  localparam int FLD_CNT   = 2;
  localparam int FLD_PER_CH = 3;
  localparam logic [2:0] OFF_SRCSEL = 3'd6;

  localparam int CTL_RUN  = 0;
  localparam int CTL_HWEN = 1;
  localparam int CTL_SWTR = 2;

  function automatic logic [2:0] reg_off(input int ch, input int fld);
    return 3'(ch * FLD_PER_CH + fld);
  endfunction
endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_s_n = stage_q[1];
endmodule

// File: rtl/dma_trig_mux.sv
module dma_trig_mux #(
  parameter int NSRC = 4,
  parameter int DW   = 32,
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr,
  input  logic [DW-1:0]    wdata,
  input  logic [NSRC-1:0]  req_in,
  output logic [SEL_W-1:0] sel,
  output logic             req_out
);
  logic [SEL_W-1:0] sel_q, sel_n;

  always_comb begin
    sel_n = sel_q;
    if (sel_wr) sel_n = wdata[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_wr) sel_q <= sel_n;
  end

  assign sel     = sel_q;
  assign req_out = req_in[sel_q];
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import flyby_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_dest,
  input  logic              wr_cnt,
  input  logic [DW-1:0]     wdata,
  input  logic              hw_req,
  input  logic              grant,
  output logic              run,
  output logic              hw_en,
  output logic [ADDR_W-1:0] dest,
  output logic [CNT_W-1:0]  count,
  output logic              pend,
  output logic              done
);
  logic              run_q, run_n;
  logic              hwen_q, hwen_n;
  logic              sw_q, sw_n;
  logic              done_q, done_n;
  logic [ADDR_W-1:0] dest_q, dest_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              cnt_nz;
  logic              upd_en;

  assign cnt_nz = (cnt_q != '0);

  always_comb begin
    run_n  = run_q;
    hwen_n = hwen_q;
    sw_n   = sw_q;
    dest_n = dest_q;
    cnt_n  = cnt_q;
    done_n = 1'b0;
    if (wr_ctrl) begin
      run_n  = wdata[CTL_RUN];
      hwen_n = wdata[CTL_HWEN];
      if (wdata[CTL_SWTR] && run_q && !hwen_q && cnt_nz) sw_n = 1'b1;
    end
    if (wr_dest && !run_q) dest_n = wdata[ADDR_W-1:0];
    if (wr_cnt  && !run_q) cnt_n  = wdata[CNT_W-1:0];
    if (grant) begin
      dest_n = dest_q + ADDR_W'(1);
      cnt_n  = cnt_q - CNT_W'(1);
      sw_n   = 1'b0;
      if (cnt_q == CNT_W'(1)) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end
    end
    if (!run_n) sw_n = 1'b0;
  end

  assign upd_en = wr_ctrl | wr_dest | wr_cnt | grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      hwen_q <= 1'b0;
      sw_q   <= 1'b0;
      dest_q <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      run_q  <= run_n;
      hwen_q <= hwen_n;
      sw_q   <= sw_n;
      dest_q <= dest_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_n;
  end

  assign pend  = run_q && cnt_nz && ((hwen_q && hw_req) || sw_q);
  assign run   = run_q;
  assign hw_en = hwen_q;
  assign dest  = dest_q;
  assign count = cnt_q;
  assign done  = done_q;
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int NCH = 2
) (
  input  logic [NCH-1:0] pend,
  output logic [NCH-1:0] grant
);
  logic [NCH:0] taken;

  assign taken[0] = 1'b0;
  for (genvar i = 0; i < NCH; i++) begin : g_prio
    assign grant[i]   = pend[i] && !taken[i];
    assign taken[i+1] = taken[i] || pend[i];
  end
endmodule

// File: rtl/flyby_dma.sv
module flyby_dma
  import flyby_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DW     = 32,
  parameter int NSRC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_waddr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic [2:0]        reg_raddr,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NSRC-1:0]   ch1_dreq,
  input  logic              ch2_dreq,
  output logic              ch1_dack,
  output logic              ch2_dack,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              ch1_done,
  output logic              ch2_done
);
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic                           rst_s_n;
  logic [SEL_W-1:0]               src_sel;
  logic                           ch1_req_sel;
  logic [NUM_CH-1:0]              hw_req_v;
  logic [NUM_CH-1:0]              run_v, hwen_v, pend_v, grant_v, done_v;
  logic [NUM_CH-1:0][ADDR_W-1:0]  dest_v;
  logic [NUM_CH-1:0][CNT_W-1:0]   cnt_v;

  logic [NUM_CH-1:0] dack_q, dack_n;
  logic              we_q, we_n;
  logic [ADDR_W-1:0] maddr_q, maddr_n;

  dma_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  dma_trig_mux #(.NSRC(NSRC), .DW(DW)) u_mux (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .sel_wr  (reg_wr && (reg_waddr == OFF_SRCSEL)),
    .wdata   (reg_wdata),
    .req_in  (ch1_dreq),
    .sel     (src_sel),
    .req_out (ch1_req_sel)
  );

  assign hw_req_v = {ch2_dreq, ch1_req_sel};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DW(DW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .wr_ctrl (reg_wr && (reg_waddr == reg_off(c, FLD_CTRL))),
      .wr_dest (reg_wr && (reg_waddr == reg_off(c, FLD_DEST))),
      .wr_cnt  (reg_wr && (reg_waddr == reg_off(c, FLD_CNT))),
      .wdata   (reg_wdata),
      .hw_req  (hw_req_v[c]),
      .grant   (grant_v[c]),
      .run     (run_v[c]),
      .hw_en   (hwen_v[c]),
      .dest    (dest_v[c]),
      .count   (cnt_v[c]),
      .pend    (pend_v[c]),
      .done    (done_v[c])
    );
  end

  dma_arb #(.NCH(NUM_CH)) u_arb (
    .pend  (pend_v),
    .grant (grant_v)
  );

  always_comb begin
    dack_n  = grant_v;
    we_n    = |grant_v;
    maddr_n = maddr_q;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (grant_v[c]) maddr_n = dest_v[c];
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      dack_q  <= '0;
      we_q    <= 1'b0;
      maddr_q <= '0;
    end else begin
      dack_q <= dack_n;
      we_q   <= we_n;
      if (we_n) maddr_q <= maddr_n;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_raddr == reg_off(c, FLD_CTRL)) reg_rdata[1:0] = {hwen_v[c], run_v[c]};
      if (reg_raddr == reg_off(c, FLD_DEST)) reg_rdata[ADDR_W-1:0] = dest_v[c];
      if (reg_raddr == reg_off(c, FLD_CNT))  reg_rdata[CNT_W-1:0]  = cnt_v[c];
    end
    if (reg_raddr == OFF_SRCSEL) reg_rdata[SEL_W-1:0] = src_sel;
  end

  assign ch1_dack = dack_q[0];
  assign ch2_dack = dack_q[1];
  assign mem_we   = we_q;
  assign mem_addr = maddr_q;
  assign ch1_done = done_v[0];
  assign ch2_done = done_v[1];
endmodule

// File: rtl/flyby_dma_chk.sv
module flyby_dma_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ch1_dack,
  input logic       ch2_dack,
  input logic       mem_we,
  input logic       ch1_done,
  input logic       ch2_done,
  input logic [1:0] run_v
);
  assert_one_dack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ch1_dack, ch2_dack}));

  assert_we_with_dack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (ch1_dack || ch2_dack));

  assert_ch1_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ch1_dack |-> $past(run_v[0]));

  assert_ch2_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ch2_dack |-> $past(run_v[1]));

  assert_done1_with_dack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ch1_done |-> (ch1_dack && !run_v[0]));

  assert_done2_with_dack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ch2_done |-> (ch2_dack && !run_v[1]));

  assert_quiet_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ch1_done |=> !ch1_dack);
endmodule

bind flyby_dma flyby_dma_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_s_n),
  .ch1_dack (ch1_dack),
  .ch2_dack (ch2_dack),
  .mem_we   (mem_we),
  .ch1_done (ch1_done),
  .ch2_done (ch2_done),
  .run_v    (run_v)
);

// File: tb/flyby_dma_tb.sv
`timescale 1ns/1ps
module flyby_dma_tb;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_waddr;
  logic [31:0] reg_wdata;
  logic [2:0]  reg_raddr;
  logic [31:0] reg_rdata;
  logic [3:0]  ch1_dreq;
  logic        ch2_dreq;
  logic        ch1_dack, ch2_dack, mem_we, ch1_done, ch2_done;
  logic [15:0] mem_addr;

  int n_tests;
  int n_fail;

  flyby_dma u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .ch1_dreq(ch1_dreq), .ch2_dreq(ch2_dreq), .ch1_dack(ch1_dack),
    .ch2_dack(ch2_dack), .mem_addr(mem_addr), .mem_we(mem_we),
    .ch1_done(ch1_done), .ch2_done(ch2_done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_raddr = a;
    #0.5;
    d = reg_rdata;
  endtask

  // outputs packed as {ch2_dack, ch1_dack, mem_we, ch2_done, ch1_done}
  function automatic logic [4:0] outs();
    return {ch2_dack, ch1_dack, mem_we, ch2_done, ch1_done};
  endfunction

  task automatic setup(input int ch, input logic [15:0] dst, input logic [15:0] cnt, input logic [1:0] ctl);
    wr(3'(ch*3), 32'd0);
    wr(3'(ch*3+1), {16'd0, dst});
    wr(3'(ch*3+2), {16'd0, cnt});
    wr(3'(ch*3), {30'd0, ctl});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 outputs", {27'd0, outs()}, 32'd0);
    check("R1 mem_addr", {16'd0, mem_addr}, 32'd0);
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check("R1 register", v, 32'd0);
    end
  endtask

  task automatic t_program_mode();
    logic [31:0] v;
    setup(0, 16'h0100, 16'd3, 2'b10);
    ch1_dreq = 4'b1111; ch2_dreq = 1'b0;
    @(negedge clk);
    check("R2 no dack in program mode", {27'd0, outs()}, 32'd0);
    ch1_dreq = 4'b0;
    rd(3'd2, v);
    check("R2 count untouched", v, 32'd3);
  endtask

  task automatic t_hw_disabled();
    logic [31:0] v;
    setup(0, 16'h0100, 16'd3, 2'b01);
    ch1_dreq = 4'b0001;
    @(negedge clk);
    check("R3 dreq ignored", {27'd0, outs()}, 32'd0);
    ch1_dreq = 4'b0;
    rd(3'd1, v);
    check("R3 dest untouched", v, 32'h100);
  endtask

  task automatic t_transfers();
    logic [31:0] v;
    setup(0, 16'h0100, 16'd3, 2'b11);
    wr(3'd1, 32'h555);
    wr(3'd2, 32'd9);
    rd(3'd1, v);
    check("R9 dest write ignored while running", v, 32'h100);
    rd(3'd2, v);
    check("R9 count write ignored while running", v, 32'd3);
    for (int k = 0; k < 3; k++) begin
      ch1_dreq = 4'b0001;
      @(negedge clk);
      ch1_dreq = 4'b0;
      check("R4 dack1+we", {27'd0, outs()}, {27'd0, 3'b011, 1'b0, (k == 2)});
      check("R4 mem_addr", {16'd0, mem_addr}, 32'h100 + 32'(k));
      rd(3'd2, v);
      check("R4 count decrements", v, 32'(2 - k));
      rd(3'd1, v);
      check("R4 dest increments", v, 32'h101 + 32'(k));
      @(negedge clk);
      check("R4 single cycle pulse", {27'd0, outs()}, 32'd0);
    end
    rd(3'd0, v);
    check("R5 run bit cleared", v, 32'b10);
    ch1_dreq = 4'b0001;
    @(negedge clk);
    @(negedge clk);
    ch1_dreq = 4'b0;
    check("R5 requests ignored after done", {27'd0, outs()}, 32'd0);
  endtask

  task automatic t_trig_sel();
    logic [31:0] v;
    setup(0, 16'h0200, 16'd10, 2'b11);
    for (int s = 0; s < 4; s++) begin
      wr(3'd6, 32'(s));
      rd(3'd6, v);
      check("R6 select readback", v, 32'(s));
      ch1_dreq = 4'b1111 & ~(4'b0001 << s);
      @(negedge clk);
      @(negedge clk);
      ch1_dreq = 4'b0;
      check("R6 unselected inputs ignored", {27'd0, outs()}, 32'd0);
      ch1_dreq = 4'b0001 << s;
      @(negedge clk);
      ch1_dreq = 4'b0;
      check("R6 selected input serves ch1", {27'd0, outs()}, 32'b01100);
      check("R6 address", {16'd0, mem_addr}, 32'h200 + 32'(s));
    end
    wr(3'd0, 32'd0);
  endtask

  task automatic t_ch2_fixed();
    setup(1, 16'h0300, 16'd4, 2'b11);
    wr(3'd6, 32'd1);
    ch1_dreq = 4'b1111;
    @(negedge clk);
    @(negedge clk);
    ch1_dreq = 4'b0;
    check("R7 ch1 inputs do not reach ch2", {27'd0, outs()}, 32'd0);
    ch2_dreq = 1'b1;
    @(negedge clk);
    ch2_dreq = 1'b0;
    check("R7 ch2 dack", {27'd0, outs()}, 32'b10100);
    check("R7 ch2 address", {16'd0, mem_addr}, 32'h300);
    wr(3'd3, 32'd0);
  endtask

  task automatic t_priority();
    wr(3'd6, 32'd0);
    setup(0, 16'h0400, 16'd4, 2'b11);
    setup(1, 16'h0500, 16'd4, 2'b11);
    ch1_dreq = 4'b0001; ch2_dreq = 1'b1;
    @(negedge clk);
    ch1_dreq = 4'b0;
    check("R8 ch1 served first", {27'd0, outs()}, 32'b01100);
    check("R8 ch1 address", {16'd0, mem_addr}, 32'h400);
    @(negedge clk);
    ch2_dreq = 1'b0;
    check("R8 ch2 served next", {27'd0, outs()}, 32'b10100);
    check("R8 ch2 address", {16'd0, mem_addr}, 32'h500);
    @(negedge clk);
    check("R8 idle after", {27'd0, outs()}, 32'd0);
    wr(3'd0, 32'd0);
    wr(3'd3, 32'd0);
  endtask

  task automatic t_sw_trigger();
    logic [31:0] v;
    int hits;
    setup(0, 16'h0600, 16'd5, 2'b01);
    wr(3'd0, 32'b101);
    check("R10 no dack one cycle after write", {27'd0, outs()}, 32'd0);
    @(negedge clk);
    check("R10 software transfer", {27'd0, outs()}, 32'b01100);
    check("R10 address", {16'd0, mem_addr}, 32'h600);
    hits = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (ch1_dack) hits++;
    end
    check("R10 exactly one transfer", 32'(hits), 32'd0);
    wr(3'd0, 32'b011);
    wr(3'd0, 32'b111);
    hits = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (ch1_dack) hits++;
    end
    check("R10 rejected with hw enable", 32'(hits), 32'd0);
    wr(3'd0, 32'd0);
    wr(3'd0, 32'b100);
    hits = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (ch1_dack) hits++;
    end
    check("R10 rejected in program mode", 32'(hits), 32'd0);
    rd(3'd2, v);
    check("R10 count after one transfer", v, 32'd4);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_waddr = '0; reg_wdata = '0;
    reg_raddr = '0; ch1_dreq = '0; ch2_dreq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_program_mode();
    t_hw_disabled();
    t_transfers();
    t_trig_sel();
    t_ch2_fixed();
    t_priority();
    t_sw_trigger();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule